// File: doc/BRIEF.md
# CAN Transmit Buffer Scheduler

This block holds three outgoing CAN messages and decides which one goes to the bus next. Host software loads a free buffer with its identifier word, data length code, payload and an 8-bit local priority. It then queues the buffer by clearing that buffer's empty flag. Software can also ask for a queued buffer to be withdrawn. Each buffer has an empty flag and an abort-acknowledge flag, and software may poll them or take a maskable interrupt.

On the bus side, the frame engine pulses `arb_strobe` each time it may start arbitration, including the retry after a failed frame. On that pulse the scheduler picks one queued buffer, drives its contents, and holds it in flight until the engine reports `tx_done` or `tx_err`. An abort request against the buffer in flight is kept pending. It takes effect only if that frame fails. After the interrupt, software reads the abort-acknowledge flag to learn whether the message was withdrawn or sent.

Top module: `can_txbuf_sched`

## Requirements
- R1: After reset all three empty flags are 1, all abort-acknowledge flags are 0 and `tx_valid` is 0.
- R2: `host_queue[i]` clears the empty flag and the abort-acknowledge flag of buffer i on the next clock, but only if that buffer is empty at the time. Otherwise it has no effect.
- R3: On `arb_strobe` with no frame in flight, the queued buffer with the numerically smallest priority is selected. On equal priorities the lowest index wins. A buffer that receives an abort request in the same cycle is not a candidate. On the next clock `tx_valid` is 1, and `tx_sel` and the frame outputs show that buffer.
- R4: `arb_strobe` has no effect while a frame is in flight, including the cycle its result arrives, and no effect when no buffer is queued.
- R5: `tx_done` while a frame is in flight sets that buffer's empty flag, leaves its abort-acknowledge at 0, and drops `tx_valid` on the next clock.
- R6: `tx_err` while a frame is in flight drops `tx_valid`. The buffer stays queued and competes again at the next `arb_strobe`, where a newly queued buffer with a smaller priority value beats it.
- R7: `host_abort[i]` on a queued buffer that is not in flight sets its empty flag and its abort-acknowledge flag on the next clock.
- R8: An abort request on the buffer in flight (earlier, or in the result cycle) is granted with empty=1 and abort-acknowledge=1 if the frame ends with `tx_err`. If the frame ends with `tx_done`, the buffer is reported as sent, with abort-acknowledge 0.
- R9: `tx_irq` is 1 exactly when some buffer has both its empty flag and its `irq_en` bit set.
- R10: A load into a buffer that is not empty, and an abort request on an empty buffer, change nothing visible at the ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_load | input | 1 | Write the fields below into buffer `host_buf` |
| host_buf | input | 2 | Buffer index for a load |
| host_id | input | 32 | Identifier and control word |
| host_dlc | input | 4 | Data length code |
| host_data | input | 64 | Payload |
| host_prio | input | 8 | Local priority, smaller value is more urgent |
| host_queue | input | 3 | Per-buffer queue strobe |
| host_abort | input | 3 | Per-buffer abort request strobe |
| irq_en | input | 3 | Per-buffer interrupt enable |
| arb_strobe | input | 1 | Arbitration opportunity |
| tx_done | input | 1 | Frame in flight sent successfully |
| tx_err | input | 1 | Frame in flight failed |
| tx_empty | output | 3 | Per-buffer empty flags |
| tx_abort_ack | output | 3 | Per-buffer abort-acknowledge flags |
| tx_irq | output | 1 | Transmit interrupt |
| tx_valid | output | 1 | A frame is in flight |
| tx_sel | output | 2 | Index of the buffer in flight |
| tx_id | output | 32 | Identifier word of the frame in flight |
| tx_dlc | output | 4 | Length code of the frame in flight |
| tx_data | output | 64 | Payload of the frame in flight |

## Verification
Assertions check, on every cycle, the following properties:
- the buffer in flight is never marked empty;
- a frame stays selected and stable until its result arrives;
- a success frees the buffer without an acknowledge;
- a queue strobe or an idle-buffer abort acts on the next clock.

The choice of the smallest priority value, the tie-break by index, the re-arbitration after an error against newly queued buffers, and the outcome of an abort raised against the buffer in flight depend on history across several frames. Only the bench's directed sequences and its random traffic, compared against a reference model, show those behaviours.

// File: rtl/can_txbuf_sched.sv
module can_txbuf_sched #(
  parameter int NBUF   = 3,
  parameter int ID_W   = 32,
  parameter int DLC_W  = 4,
  parameter int DATA_W = 64,
  parameter int PRIO_W = 8,
  localparam int BUF_W = $clog2(NBUF)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_load,
  input  logic [BUF_W-1:0]  host_buf,
  input  logic [ID_W-1:0]   host_id,
  input  logic [DLC_W-1:0]  host_dlc,
  input  logic [DATA_W-1:0] host_data,
  input  logic [PRIO_W-1:0] host_prio,
  input  logic [NBUF-1:0]   host_queue,
  input  logic [NBUF-1:0]   host_abort,
  input  logic [NBUF-1:0]   irq_en,
  input  logic              arb_strobe,
  input  logic              tx_done,
  input  logic              tx_err,
  output logic [NBUF-1:0]   tx_empty,
  output logic [NBUF-1:0]   tx_abort_ack,
  output logic              tx_irq,
  output logic              tx_valid,
  output logic [BUF_W-1:0]  tx_sel,
  output logic [ID_W-1:0]   tx_id,
  output logic [DLC_W-1:0]  tx_dlc,
  output logic [DATA_W-1:0] tx_data
);

  logic [ID_W-1:0]   id_q   [NBUF];
  logic [DLC_W-1:0]  dlc_q  [NBUF];
  logic [DATA_W-1:0] data_q [NBUF];
  logic [PRIO_W-1:0] prio_q [NBUF];

  logic [NBUF-1:0]   empty_q, ack_q, pend_q, infl, load_en, cand;
  logic              busy_q, found;
  logic [BUF_W-1:0]  sel_q, best_idx;
  logic [PRIO_W-1:0] best_prio;

  always_comb begin
    for (int i = 0; i < NBUF; i++) begin
      infl[i]    = busy_q && (sel_q == BUF_W'(i));
      load_en[i] = host_load && (host_buf == BUF_W'(i)) && empty_q[i];
    end
  end

  assign cand = ~empty_q & ~host_abort;

  always_comb begin
    found     = 1'b0;
    best_idx  = '0;
    best_prio = '1;
    for (int i = 0; i < NBUF; i++) begin
      if (cand[i] && (!found || prio_q[i] < best_prio)) begin
        found     = 1'b1;
        best_idx  = BUF_W'(i);
        best_prio = prio_q[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sel_q  <= '0;
    end else if (busy_q) begin
      if (tx_done || tx_err) busy_q <= 1'b0;
    end else if (arb_strobe && found) begin
      busy_q <= 1'b1;
      sel_q  <= best_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_q <= '1;
      ack_q   <= '0;
      pend_q  <= '0;
    end else begin
      for (int i = 0; i < NBUF; i++) begin
        if (infl[i]) begin
          if (tx_done) begin
            empty_q[i] <= 1'b1;
            ack_q[i]   <= 1'b0;
            pend_q[i]  <= 1'b0;
          end else if (tx_err) begin
            if (pend_q[i] || host_abort[i]) begin
              empty_q[i] <= 1'b1;
              ack_q[i]   <= 1'b1;
            end
            pend_q[i] <= 1'b0;
          end else if (host_abort[i]) begin
            pend_q[i] <= 1'b1;
          end
        end else if (!empty_q[i]) begin
          if (host_abort[i]) begin
            empty_q[i] <= 1'b1;
            ack_q[i]   <= 1'b1;
          end
        end else if (host_queue[i]) begin
          empty_q[i] <= 1'b0;
          ack_q[i]   <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NBUF; i++) begin
        id_q[i]   <= '0;
        dlc_q[i]  <= '0;
        data_q[i] <= '0;
        prio_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NBUF; i++) begin
        if (load_en[i]) begin
          id_q[i]   <= host_id;
          dlc_q[i]  <= host_dlc;
          data_q[i] <= host_data;
          prio_q[i] <= host_prio;
        end
      end
    end
  end

  assign tx_empty     = empty_q;
  assign tx_abort_ack = ack_q;
  assign tx_irq       = |(empty_q & irq_en);
  assign tx_valid     = busy_q;
  assign tx_sel       = sel_q;
  assign tx_id        = id_q[sel_q];
  assign tx_dlc       = dlc_q[sel_q];
  assign tx_data      = data_q[sel_q];

  a_r3_sel_queued: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !tx_empty[tx_sel]);

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_done && !tx_err) |=> (tx_valid && $stable(tx_sel)));

  a_r5_sent: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_done) |=>
      (!tx_valid && tx_empty[$past(tx_sel)] && !tx_abort_ack[$past(tx_sel)]));

  for (genvar g = 0; g < NBUF; g++) begin : g_chk
    a_r7_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (host_abort[g] && !tx_empty[g] && !(tx_valid && tx_sel == BUF_W'(g)))
        |=> (tx_empty[g] && tx_abort_ack[g]));

    a_r2_queue: assert property (@(posedge clk) disable iff (!rst_n)
      (host_queue[g] && tx_empty[g]) |=> (!tx_empty[g] && !tx_abort_ack[g]));
  end

endmodule

// File: tb/can_txbuf_sched_tb.sv
`timescale 1ns/1ps
module can_txbuf_sched_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_load = 1'b0;
  logic [1:0]  host_buf = '0;
  logic [31:0] host_id = '0;
  logic [3:0]  host_dlc = '0;
  logic [63:0] host_data = '0;
  logic [7:0]  host_prio = '0;
  logic [2:0]  host_queue = '0, host_abort = '0, irq_en = '0;
  logic        arb_strobe = 1'b0, tx_done = 1'b0, tx_err = 1'b0;
  logic [2:0]  tx_empty, tx_abort_ack;
  logic        tx_irq, tx_valid;
  logic [1:0]  tx_sel;
  logic [31:0] tx_id;
  logic [3:0]  tx_dlc;
  logic [63:0] tx_data;

  can_txbuf_sched u_dut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  logic [2:0]  m_empty, m_ack, m_pend;
  logic        m_valid;
  logic [1:0]  m_sel;
  logic [31:0] m_id [3];
  logic [3:0]  m_dlc [3];
  logic [63:0] m_data [3];
  logic [7:0]  m_prio [3];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int pick(input logic [2:0] cand);
    int b = -1;
    for (int i = 0; i < 3; i++)
      if (cand[i] && (b < 0 || m_prio[i] < m_prio[b])) b = i;
    return b;
  endfunction

  task automatic step();
    logic [2:0] ne, na, np;
    logic nv;
    logic [1:0] ns;
    int b;
    ne = m_empty; na = m_ack; np = m_pend; nv = m_valid; ns = m_sel;
    for (int i = 0; i < 3; i++) begin
      if (m_valid && m_sel == 2'(i)) begin
        if (tx_done) begin ne[i] = 1; na[i] = 0; np[i] = 0; end
        else if (tx_err) begin
          if (m_pend[i] || host_abort[i]) begin ne[i] = 1; na[i] = 1; end
          np[i] = 0;
        end else if (host_abort[i]) np[i] = 1;
      end else if (!m_empty[i]) begin
        if (host_abort[i]) begin ne[i] = 1; na[i] = 1; end
      end else if (host_queue[i]) begin ne[i] = 0; na[i] = 0; end
    end
    if (m_valid) begin
      if (tx_done || tx_err) nv = 0;
    end else if (arb_strobe) begin
      b = pick(~m_empty & ~host_abort);
      if (b >= 0) begin nv = 1; ns = 2'(b); end
    end
    if (host_load && host_buf < 3 && m_empty[host_buf]) begin
      m_id[host_buf] = host_id; m_dlc[host_buf] = host_dlc;
      m_data[host_buf] = host_data; m_prio[host_buf] = host_prio;
    end
    m_empty = ne; m_ack = na; m_pend = np; m_valid = nv; m_sel = ns;
    @(negedge clk);
    host_load = 0; host_queue = 0; host_abort = 0;
    arb_strobe = 0; tx_done = 0; tx_err = 0;
    chk("R2 empty flags", 64'(tx_empty), 64'(m_empty));
    chk("R7 abort ack flags", 64'(tx_abort_ack), 64'(m_ack));
    chk("R3 valid", 64'(tx_valid), 64'(m_valid));
    chk("R9 irq", 64'(tx_irq), 64'(|(m_empty & irq_en)));
    if (m_valid) begin
      chk("R3 sel", 64'(tx_sel), 64'(m_sel));
      chk("R3 id", 64'(tx_id), 64'(m_id[m_sel]));
      chk("R3 dlc", 64'(tx_dlc), 64'(m_dlc[m_sel]));
      chk("R3 data", tx_data, m_data[m_sel]);
    end
  endtask

  task automatic load(input int b, input logic [7:0] p, input logic [31:0] id);
    host_load = 1; host_buf = 2'(b); host_prio = p; host_id = id;
    host_dlc = 4'(b + 1); host_data = {id, ~id};
    step();
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    if (!finished) begin
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    m_empty = '1; m_ack = '0; m_pend = '0; m_valid = 0; m_sel = '0;
    for (int i = 0; i < 3; i++) begin
      m_id[i] = '0; m_dlc[i] = '0; m_data[i] = '0; m_prio[i] = '0;
    end
    irq_en = 3'b101;
    repeat (3) @(negedge clk);
    chk("R1 empty after reset", 64'(tx_empty), 64'h7);
    chk("R1 ack after reset", 64'(tx_abort_ack), 64'h0);
    chk("R1 valid after reset", 64'(tx_valid), 64'h0);
    rst_n = 1;
    @(negedge clk);

    // R4: strobe with nothing queued
    arb_strobe = 1; step();
    chk("R4 idle strobe", 64'(tx_valid), 64'h0);

    // R3: tie on priority goes to lower index
    load(0, 8'd5, 32'hA0); load(1, 8'd5, 32'hA1); load(2, 8'd9, 32'hA2);
    host_queue = 3'b111; step();
    arb_strobe = 1; step();
    chk("R3 tie lower index", 64'(tx_sel), 64'h0);

    // R4: strobe while busy ignored
    arb_strobe = 1; step();
    chk("R4 busy strobe sel", 64'(tx_sel), 64'h0);

    // R8: abort in flight, then error -> granted
    host_abort = 3'b001; step();
    chk("R8 pending keeps frame", 64'(tx_valid), 64'h1);
    tx_err = 1; step();
    chk("R8 err grants abort ack", 64'(tx_abort_ack[0]), 64'h1);
    chk("R8 err grants empty", 64'(tx_empty[0]), 64'h1);

    arb_strobe = 1; step();
    chk("R3 next lowest prio", 64'(tx_sel), 64'h1);

    // R10: load into non-empty buffer ignored
    load(1, 8'd0, 32'hDEAD);
    chk("R10 id unchanged", 64'(tx_id), 64'hA1);

    // R8: abort in flight, then success -> sent
    host_abort = 3'b010; step();
    tx_done = 1; step();
    chk("R8 done ack zero", 64'(tx_abort_ack[1]), 64'h0);
    chk("R5 done empty", 64'(tx_empty[1]), 64'h1);

    // R6: error then re-arbitration loses to new urgent buffer
    arb_strobe = 1; step();
    chk("R6 sel buffer2", 64'(tx_sel), 64'h2);
    tx_err = 1; step();
    chk("R6 stays queued", 64'(tx_empty[2]), 64'h0);
    load(0, 8'd1, 32'hB0);
    host_queue = 3'b001; step();
    arb_strobe = 1; step();
    chk("R6 new urgent wins", 64'(tx_sel), 64'h0);
    tx_done = 1; step();

    // R7: abort of idle queued buffer
    host_abort = 3'b100; step();
    chk("R7 idle abort ack", 64'(tx_abort_ack[2]), 64'h1);
    // R10: abort on empty buffer ignored
    host_abort = 3'b001; step();
    chk("R10 empty abort no ack", 64'(tx_abort_ack[0]), 64'h0);

    // R2: queue clears ack
    host_queue = 3'b100; step();
    chk("R2 queue clears ack", 64'(tx_abort_ack[2]), 64'h0);

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      host_load  = $urandom_range(1, 0) == 1;
      host_buf   = 2'($urandom_range(3, 0));
      host_id    = $urandom;
      host_dlc   = 4'($urandom_range(15, 0));
      host_data  = {$urandom, $urandom};
      host_prio  = 8'($urandom_range(3, 0));
      host_queue = 3'($urandom & $urandom);
      host_abort = ($urandom_range(7, 0) == 0) ? 3'($urandom) : 3'b000;
      arb_strobe = $urandom_range(2, 0) == 0;
      if (m_valid) begin
        int r = $urandom_range(5, 0);
        tx_done = (r == 0);
        tx_err  = (r == 1);
      end
      if ($urandom_range(31, 0) == 0) irq_en = 3'($urandom);
      step();
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule